// File: doc/BRIEF.md
# Sequential Address Freeze Codec

This block lowers switching on a processor address bus by exploiting the fact that most fetched addresses follow the previous one by a fixed stride. An encoder on the sending side compares each new address with the last one it accepted. When the new address is exactly the last one plus the stride, it leaves the address lines where they are and raises a single side wire that marks the word as "next in sequence". Otherwise the side wire stays low and the address is driven on the lines unchanged.

A decoder on the receiving side mirrors this. It keeps its own register holding the last address it rebuilt, separate from the frozen bus value. When the side wire is high it adds the stride to that register; when it is low it takes the address from the lines. Encoder, bus register and decoder are packaged together here so the whole point-to-point link can be checked end to end, but the bus-side ports are exposed so the encoded lines can be observed.

Top module: `seq_freeze_codec`

## Requirements
- R1: An address presented with `addr_vld` high at a rising edge appears as a bus word (`bus_vld` high) on the next cycle, and the decoded copy appears on `dec_addr` with `dec_vld` high one cycle after that, equal to the address that was presented.
- R2: The first address accepted after reset is always sent with `bus_inc` low and its value on `bus_addr`, even if it equals the reset value plus the stride.
- R3: When an accepted address equals the previously accepted address plus `STRIDE`, `bus_inc` is 1 and `bus_addr` keeps its previous value, so a run of in-sequence addresses causes no transitions on the address lines.
- R4: When an accepted address is not the previous one plus `STRIDE`, `bus_inc` is 0 and `bus_addr` equals that address.
- R5: When a bus word arrives with `bus_inc` high, the decoder outputs its previous decoded address plus `STRIDE`.
- R6: The sequence test and the decoder's addition both wrap modulo 2^`ADDR_W`, so the address after the top of the space (all ones minus `STRIDE` plus one) is zero and still counts as in sequence.
- R7: Cycles with `addr_vld` low do not break a sequence: `bus_vld` and `bus_inc` are 0, `bus_addr` holds, and the next accepted address is compared with the last accepted one.
- R8: While `rst_n` is low at a rising edge, every output is cleared to zero on that edge.
- R9: An address that repeats the previous one (difference zero) is not in sequence and is sent with `bus_inc` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | Address to send |
| addr_vld | input | 1 | `addr_in` is valid this cycle |
| bus_addr | output | ADDR_W | Encoded address lines |
| bus_inc | output | 1 | Side wire: word is previous plus stride |
| bus_vld | output | 1 | A bus word is present this cycle |
| dec_addr | output | ADDR_W | Address rebuilt by the decoder |
| dec_vld | output | 1 | `dec_addr` carries a new address this cycle |

## Verification
The bench builds the codec with a 32-bit address and a stride of 4, which puts the wrap from 0xFFFFFFFC to zero within reach of a short run and makes a repeated address distinct from a sequential one. A behavioural model predicts the bus word, the side wire and the decoded address on every clock, and a transition counter confirms that a long in-sequence run leaves the address lines untouched. Idle gaps inside a run, a mid-test reset followed by an address that would otherwise be in sequence, and a pseudo-random mix of jumps and steps are driven as well.

// File: rtl/sfz_pkg.sv
// Shared defaults for the sequential address freeze codec.
// Assumes: nothing; holds only constants used as parameter defaults.
package sfz_pkg;
    localparam int unsigned SFZ_ADDR_W_DEF = 32;
    localparam int unsigned SFZ_STRIDE_DEF = 4;
endpackage

// File: rtl/sfz_enc.sv
// Encoder: freezes the address lines and raises the side wire when the
// accepted address is the previous accepted address plus STRIDE.
// Assumes: STRIDE is nonzero and smaller than 2^ADDR_W.
module sfz_enc #(
    parameter int unsigned ADDR_W = sfz_pkg::SFZ_ADDR_W_DEF,
    parameter int unsigned STRIDE = sfz_pkg::SFZ_STRIDE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_vld,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_inc,
    output logic              bus_vld
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] last_addr;
    logic              have_last;
    logic              in_seq;

    // Decide whether the incoming address continues the sequence.
    always_comb begin
        in_seq = have_last && (addr_in == last_addr + STEP);
    end

    // Drive the bus word and remember the last accepted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_inc   <= 1'b0;
            bus_vld   <= 1'b0;
            last_addr <= '0;
            have_last <= 1'b0;
        end else if (addr_vld) begin
            bus_inc   <= in_seq;
            bus_vld   <= 1'b1;
            last_addr <= addr_in;
            have_last <= 1'b1;
            if (!in_seq) bus_addr <= addr_in;
        end else begin
            bus_inc <= 1'b0;
            bus_vld <= 1'b0;
        end
    end

    // R2
    first_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !have_last) |=> !bus_inc);
    // R3
    frozen_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_inc) |-> $stable(bus_addr));
    // R4
    plain_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_inc) |-> (bus_addr == $past(addr_in)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> ($stable(bus_addr) && !bus_vld && !bus_inc));
endmodule

// File: rtl/sfz_dec.sv
// Decoder: rebuilds the address from the bus word, adding STRIDE to its
// own last decoded address when the side wire is high.
// Assumes: the bus word comes from an sfz_enc with the same parameters.
module sfz_dec #(
    parameter int unsigned ADDR_W = sfz_pkg::SFZ_ADDR_W_DEF,
    parameter int unsigned STRIDE = sfz_pkg::SFZ_STRIDE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_inc,
    input  logic              bus_vld,
    output logic [ADDR_W-1:0] dec_addr,
    output logic              dec_vld
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    // Rebuild the address and hold it between words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_addr <= '0;
            dec_vld  <= 1'b0;
        end else begin
            dec_vld <= bus_vld;
            if (bus_vld) dec_addr <= bus_inc ? dec_addr + STEP : bus_addr;
        end
    end

    // R5
    local_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_inc) |=> (dec_addr == $past(dec_addr) + STEP));
    // R4
    plain_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_inc) |=> (dec_addr == $past(bus_addr)));
endmodule

// File: rtl/seq_freeze_codec.sv
// Top: encoder and decoder of one point-to-point address link, with the
// encoded lines brought out for observation.
// Assumes: STRIDE is nonzero; one address per cycle at most.
module seq_freeze_codec #(
    parameter int unsigned ADDR_W = sfz_pkg::SFZ_ADDR_W_DEF,
    parameter int unsigned STRIDE = sfz_pkg::SFZ_STRIDE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_vld,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_inc,
    output logic              bus_vld,
    output logic [ADDR_W-1:0] dec_addr,
    output logic              dec_vld
);
    sfz_enc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_vld(addr_vld),
        .bus_addr(bus_addr), .bus_inc(bus_inc), .bus_vld(bus_vld)
    );

    sfz_dec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_inc(bus_inc),
        .bus_vld(bus_vld), .dec_addr(dec_addr), .dec_vld(dec_vld)
    );

    // R1
    pipe_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |=> bus_vld);
endmodule

// File: tb/seq_freeze_codec_tb.sv
module seq_freeze_codec_tb;
    localparam int W = 32;
    localparam int STRIDE = 4;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] addr_in = '0;
    logic addr_vld = 1'b0;
    logic [W-1:0] bus_addr, dec_addr;
    logic bus_inc, bus_vld, dec_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    bit m_have, m_inc, m_bvld, m_dvld;
    logic [W-1:0] m_prev, m_bus, m_dec;
    logic [W-1:0] sent_q[$];
    logic [W-1:0] last_bus;
    int flips;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_freeze_codec #(.ADDR_W(W), .STRIDE(STRIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_vld(addr_vld),
        .bus_addr(bus_addr), .bus_inc(bus_inc), .bus_vld(bus_vld),
        .dec_addr(dec_addr), .dec_vld(dec_vld)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_have = 0; m_inc = 0; m_bvld = 0; m_dvld = 0;
        m_prev = '0; m_bus = '0; m_dec = '0;
        sent_q.delete();
        last_bus = '0;
    endtask

    // R8: synchronous reset clears all outputs
    task automatic do_reset();
        rst_n = 1'b0; addr_vld = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 bus_addr", bus_addr, '0);
        check("R8 bus_inc", W'(bus_inc), '0);
        check("R8 bus_vld", W'(bus_vld), '0);
        check("R8 dec_addr", dec_addr, '0);
        check("R8 dec_vld", W'(dec_vld), '0);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One cycle: drive, let the edge pass, update model, compare all outputs.
    task automatic step(input bit v, input logic [W-1:0] a, input string tag);
        bit sq;
        addr_vld = v; addr_in = a;
        @(posedge clk);
        @(negedge clk);
        m_dvld = m_bvld;
        if (m_bvld) m_dec = sent_q.pop_front();
        if (v) begin
            sq = m_have && (a == m_prev + W'(STRIDE));
            m_inc = sq;
            if (!sq) m_bus = a;
            m_bvld = 1; m_prev = a; m_have = 1;
            sent_q.push_back(a);
        end else begin
            m_bvld = 0; m_inc = 0;
        end
        if (m_inc) flips += $countones(bus_addr ^ last_bus);
        last_bus = bus_addr;
        check({tag, " bus_vld"}, W'(bus_vld), W'(m_bvld));
        check({tag, " bus_inc"}, W'(bus_inc), W'(m_inc));
        check({tag, " bus_addr"}, bus_addr, m_bus);
        check({tag, " dec_vld"}, W'(dec_vld), W'(m_dvld));
        check({tag, " dec_addr"}, dec_addr, m_dec);
    endtask

    initial begin
        logic [W-1:0] lfsr;
        logic [W-1:0] cur;
        model_clear();
        flips = 0;
        do_reset();

        // R2: first address equals reset value + stride, still plain
        step(1, W'(STRIDE), "R2");
        check("R2 first inc low", W'(bus_inc), '0);
        step(1, 32'h0000_1000, "R4");
        // R3 / R5 / R1: long in-sequence run
        flips = 0;
        cur = 32'h0000_1000;
        for (int i = 0; i < 24; i++) begin
            cur = cur + W'(STRIDE);
            step(1, cur, "R3 R5");
        end
        step(0, '0, "R1");
        check("R3 zero flips in run", W'(flips), '0);
        step(0, '0, "R1");
        // R4: jump, R9: repeat
        step(1, 32'h8000_0040, "R4");
        step(1, 32'h8000_0040, "R9");
        check("R9 repeat inc low", W'(bus_inc), '0);
        step(1, 32'h8000_0048, "R4");
        // R7: gaps inside a sequence
        step(0, 32'hDEAD_BEEF, "R7");
        step(0, 32'h0, "R7");
        step(1, 32'h8000_004C, "R7");
        check("R7 seq kept over gap", W'(bus_inc), 32'd1);
        // R6: wrap
        step(1, 32'hFFFF_FFF8, "R6");
        step(1, 32'hFFFF_FFFC, "R6");
        step(1, 32'h0000_0000, "R6");
        check("R6 wrap inc", W'(bus_inc), 32'd1);
        step(1, 32'h0000_0004, "R6");
        step(0, '0, "R6");
        step(0, '0, "R6");
        check("R6 wrapped decode", dec_addr, 32'h4);
        // R2 after mid-test reset
        step(1, 32'h0000_2000, "R2");
        do_reset();
        step(1, 32'h0000_2004, "R2");
        check("R2 after reset inc low", W'(bus_inc), '0);
        // pseudo-random mix
        lfsr = 32'hACE1_1234;
        cur = 32'h0000_4000;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[2:0] == 3'd0) cur = lfsr;
            else if (lfsr[2:0] == 3'd1) cur = cur;
            else cur = cur + W'(STRIDE);
            step(lfsr[5:3] != 3'd0, cur, "R1 R3 R4 mix");
        end
        step(0, '0, "R1");
        step(0, '0, "R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule